// File: doc/BRIEF.md
# Two-Thread Partitioned Store Buffer

This block holds the in-flight stores of a core that runs two hardware threads at once. A store is written into the buffer when it executes, carrying its byte address, a data word and a byte-enable mask. It stays there through retirement and is drained toward the L1 data cache some time later. Each thread owns a fixed half of the entries. A thread can fill only its own half, so a full thread stalls only itself.

Loads probe the buffer with a word address, a byte mask and the id of their thread. The probe searches only the entries of the probing thread, and it includes stores that have not yet retired. The sibling thread therefore sees a store only once that store has been committed to the cache. Retire pulses mark the oldest speculative store of a thread as final. A flush drops the speculative stores of one thread. A commit port sends retired stores to the cache in program order for each thread, and alternates between the threads when both have work waiting.

Top module: `smt_store_buffer`

## Requirements
- R1: After reset both partitions are empty: `st_ready` is 2'b11, `cm_valid` is 0, and a probe reports neither hit nor blocked.
- R2: A store presented with `st_valid[t]` and `st_ready[t]` high is written at that clock edge. From the next cycle it is visible to probes of thread t, even though it has not retired.
- R3: Each thread holds at most DEPTH entries. `st_ready[t]` is low when thread t holds DEPTH entries or `flush[t]` is high, and the fill level of one thread never affects the other thread.
- R4: Only retired entries are offered on the commit port. The entries of each thread leave in the order they were stored, and the full stored address, data and mask are presented.
- R5: When no transfer is stalled and both threads have retired entries, the grant goes to the thread that was not granted last. After reset, thread 1 counts as the last one granted. With only one thread requesting, that thread is granted.
- R6: While `cm_valid` is high and `cm_ready` is low, `cm_valid`, `cm_tid`, `cm_addr`, `cm_data` and `cm_mask` hold their values into the next cycle.
- R7: A probe compares its word address with the address bits above the byte offset of each entry. It selects the youngest entry of its thread whose mask overlaps the load mask. If that entry's mask covers every load byte, `ld_hit`=1 and `ld_data` is that entry's data word. Otherwise `ld_blocked`=1. With no overlapping entry, or with `ld_valid` low, both flags are 0.
- R8: A probe never returns a result based on the other thread's entries.
- R9: `flush[t]` drops every non-retired entry of thread t and keeps its retired entries. A store or retire pulse of thread t in the same cycle is ignored. A commit of thread t in that cycle still takes place.
- R10: A retire pulse marks the oldest non-retired entry of that thread as retired. A pulse with no non-retired entry present has no effect.
- R11: A commit handshake (`cm_valid` and `cm_ready` both high) removes that entry. From the next cycle it no longer answers probes and no longer counts toward its thread's capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 2 | Executing store per thread |
| st_ready | output | 2 | Thread can accept a store this cycle |
| st_addr | input | 2 x AW | Store byte address per thread |
| st_data | input | 2 x DW | Store data word per thread |
| st_mask | input | 2 x DW/8 | Store byte enables per thread |
| retire | input | 2 | Retire pulse per thread |
| flush | input | 2 | Drop speculative stores per thread |
| cm_valid | output | 1 | Retired store offered to cache |
| cm_ready | input | 1 | Cache accepts the offered store |
| cm_tid | output | 1 | Thread of the offered store |
| cm_addr | output | AW | Address of the offered store |
| cm_data | output | DW | Data of the offered store |
| cm_mask | output | DW/8 | Byte enables of the offered store |
| ld_valid | input | 1 | Load probe active |
| ld_tid | input | 1 | Thread of the probing load |
| ld_word | input | AW - log2(DW/8) | Word address of the load |
| ld_mask | input | DW/8 | Bytes the load reads |
| ld_hit | output | 1 | Whole load forwarded |
| ld_blocked | output | 1 | Youngest overlap covers the load only in part |
| ld_data | output | DW | Forwarded data word |

## Verification
Every output is a combinational function of the registered state and the inputs of the current cycle. `st_ready`, the commit outputs and the probe result are therefore due in the same cycle as the inputs that drive them. A store, retire, flush or commit changes what is observed from the cycle after its clock edge. The bench drives its inputs on the falling edge and compares every output against a queue-based model 2 ns later. It then advances the model by exactly one edge, so every result is checked in the cycle it is due. The stall-hold rule is checked one cycle after each stalled offer, against the payload recorded in that cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int unsigned N_THR = 2;

    typedef enum logic [1:0] {
        PROBE_MISS  = 2'd0,
        PROBE_HIT   = 2'd1,
        PROBE_BLOCK = 2'd2
    } probe_res_e;
endpackage

// File: rtl/sq_fwd_probe.sv
module sq_fwd_probe
    import sq_pkg::*;
#(
    parameter int DW    = 64,
    parameter int WW    = 29,
    parameter int DEPTH = 8,
    localparam int BW   = DW / 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [WW-1:0] q_word,
    input  logic [BW-1:0] q_mask,
    input  logic [PW-1:0] head,
    input  logic [PW:0]   cnt,
    input  logic [WW-1:0] e_word [DEPTH],
    input  logic [DW-1:0] e_data [DEPTH],
    input  logic [BW-1:0] e_mask [DEPTH],
    output probe_res_e    res,
    output logic [DW-1:0] data
);
    logic          found;
    logic [PW-1:0] sel;
    logic [PW-1:0] idx;

    // scan oldest to youngest; later matches override earlier ones
    always_comb begin
        found = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (((PW+1)'(k) < cnt) && (e_word[idx] == q_word)
                && (|(e_mask[idx] & q_mask))) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end

    always_comb begin
        if (!found)
            res = PROBE_MISS;
        else if ((e_mask[sel] & q_mask) == q_mask)
            res = PROBE_HIT;
        else
            res = PROBE_BLOCK;
        data = e_data[sel];
    end
endmodule

// File: rtl/sq_thread_part.sv
module sq_thread_part
    import sq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    localparam int BW   = DW / 8,
    localparam int OFF  = $clog2(BW),
    localparam int WW   = AW - OFF,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [BW-1:0] push_mask,
    input  logic          retire,
    input  logic          flush,
    input  logic          pop,
    input  logic [WW-1:0] probe_word,
    input  logic [BW-1:0] probe_mask,
    output logic          full,
    output logic          ret_any,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [BW-1:0] head_mask,
    output probe_res_e    probe_res,
    output logic [DW-1:0] probe_data
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [PW:0]   cnt;
        logic [PW:0]   ret;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic [AW-1:0] addr_d [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_d [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [BW-1:0] mask_d [DEPTH];
    logic [BW-1:0] mask_q [DEPTH];
    logic [WW-1:0] word_q [DEPTH];
    logic          push_ok;
    logic          retire_ok;

    always_comb begin
        push_ok   = push && !flush && (c_q.cnt != (PW+1)'(DEPTH));
        retire_ok = retire && !flush && (c_q.ret < c_q.cnt);
        c_d       = c_q;
        addr_d    = addr_q;
        data_d    = data_q;
        mask_d    = mask_q;

        c_d.head = c_q.head + PW'(pop);
        c_d.ret  = c_q.ret + (PW+1)'(retire_ok) - (PW+1)'(pop);
        if (flush) begin
            c_d.cnt  = c_q.ret - (PW+1)'(pop);
            c_d.tail = c_d.head + c_d.cnt[PW-1:0];
        end else begin
            c_d.cnt  = c_q.cnt + (PW+1)'(push_ok) - (PW+1)'(pop);
            c_d.tail = c_q.tail + PW'(push_ok);
        end

        if (push_ok) begin
            addr_d[c_q.tail] = push_addr;
            data_d[c_q.tail] = push_data;
            mask_d[c_q.tail] = push_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
        mask_q <= mask_d;
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++)
            word_q[k] = addr_q[k][AW-1:OFF];
    end

    assign full      = (c_q.cnt == (PW+1)'(DEPTH));
    assign ret_any   = (c_q.ret != '0);
    assign head_addr = addr_q[c_q.head];
    assign head_data = data_q[c_q.head];
    assign head_mask = mask_q[c_q.head];

    sq_fwd_probe #(.DW(DW), .WW(WW), .DEPTH(DEPTH)) i_probe (
        .q_word (probe_word),
        .q_mask (probe_mask),
        .head   (c_q.head),
        .cnt    (c_q.cnt),
        .e_word (word_q),
        .e_data (data_q),
        .e_mask (mask_q),
        .res    (probe_res),
        .data   (probe_data)
    );

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= (PW+1)'(DEPTH));
    assert_retired_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.ret <= c_q.cnt);
    assert_commit_only_retired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (c_q.ret != '0));
    assert_flush_keeps_retired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (c_q.cnt == c_q.ret));
endmodule

// File: rtl/sq_commit_arb.sv
module sq_commit_arb
    import sq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_THR-1:0] req,
    input  logic             ready,
    output logic             valid,
    output logic             sel,
    output logic             fire
);
    typedef struct packed {
        logic last;
        logic lock;
        logic sel;
    } arb_t;

    arb_t a_d, a_q;

    always_comb begin
        if (a_q.lock)
            sel = a_q.sel;
        else if (req == 2'b11)
            sel = !a_q.last;
        else
            sel = req[1];
        valid = |req;
        fire  = valid && ready;

        a_d      = a_q;
        a_d.last = fire ? sel : a_q.last;
        a_d.lock = valid && !ready;
        a_d.sel  = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '{last: 1'b1, lock: 1'b0, sel: 1'b0};
        else        a_q <= a_d;
    end

    assert_locked_request_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.lock |-> req[a_q.sel]);
endmodule

// File: rtl/smt_store_buffer.sv
module smt_store_buffer
    import sq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    localparam int BW   = DW / 8,
    localparam int OFF  = $clog2(BW),
    localparam int WW   = AW - OFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_THR-1:0]          st_valid,
    output logic [N_THR-1:0]          st_ready,
    input  logic [N_THR-1:0][AW-1:0]  st_addr,
    input  logic [N_THR-1:0][DW-1:0]  st_data,
    input  logic [N_THR-1:0][BW-1:0]  st_mask,
    input  logic [N_THR-1:0]          retire,
    input  logic [N_THR-1:0]          flush,
    output logic                      cm_valid,
    input  logic                      cm_ready,
    output logic                      cm_tid,
    output logic [AW-1:0]             cm_addr,
    output logic [DW-1:0]             cm_data,
    output logic [BW-1:0]             cm_mask,
    input  logic                      ld_valid,
    input  logic                      ld_tid,
    input  logic [WW-1:0]             ld_word,
    input  logic [BW-1:0]             ld_mask,
    output logic                      ld_hit,
    output logic                      ld_blocked,
    output logic [DW-1:0]             ld_data
);
    logic [N_THR-1:0] full;
    logic [N_THR-1:0] ret_any;
    logic [AW-1:0]    h_addr [N_THR];
    logic [DW-1:0]    h_data [N_THR];
    logic [BW-1:0]    h_mask [N_THR];
    probe_res_e       p_res  [N_THR];
    logic [DW-1:0]    p_data [N_THR];
    logic             cm_fire;

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        assign st_ready[t] = !full[t] && !flush[t];

        sq_thread_part #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_part (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (st_valid[t] && st_ready[t]),
            .push_addr  (st_addr[t]),
            .push_data  (st_data[t]),
            .push_mask  (st_mask[t]),
            .retire     (retire[t]),
            .flush      (flush[t]),
            .pop        (cm_fire && (cm_tid == 1'(t))),
            .probe_word (ld_word),
            .probe_mask (ld_mask),
            .full       (full[t]),
            .ret_any    (ret_any[t]),
            .head_addr  (h_addr[t]),
            .head_data  (h_data[t]),
            .head_mask  (h_mask[t]),
            .probe_res  (p_res[t]),
            .probe_data (p_data[t])
        );
    end

    sq_commit_arb i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ret_any),
        .ready (cm_ready),
        .valid (cm_valid),
        .sel   (cm_tid),
        .fire  (cm_fire)
    );

    assign cm_addr = h_addr[cm_tid];
    assign cm_data = h_data[cm_tid];
    assign cm_mask = h_mask[cm_tid];

    // only the probing thread's partition is consulted
    assign ld_hit     = ld_valid && (p_res[ld_tid] == PROBE_HIT);
    assign ld_blocked = ld_valid && (p_res[ld_tid] == PROBE_BLOCK);
    assign ld_data    = p_data[ld_tid];

    assert_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_tid) && $stable(cm_addr)
                                     && $stable(cm_data) && $stable(cm_mask)));
    assert_single_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_blocked));
    assert_ready_when_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush != '0) |-> ((st_ready & flush) == '0));
endmodule

// File: tb/test_smt_store_buffer.sv
`timescale 1ns/1ps
module test_smt_store_buffer;
    localparam int AW = 32, DW = 64, DEPTH = 8, BW = 8, WW = 29;
    localparam int CYCLES = 6000;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [BW-1:0] m;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] st_valid = '0, st_ready, retire = '0, flush = '0;
    logic [1:0][AW-1:0] st_addr = '0;
    logic [1:0][DW-1:0] st_data = '0;
    logic [1:0][BW-1:0] st_mask = '0;
    logic cm_valid, cm_ready = 1'b0, cm_tid;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data, ld_data;
    logic [BW-1:0] cm_mask, ld_mask = '0;
    logic ld_valid = 1'b0, ld_tid = 1'b0, ld_hit, ld_blocked;
    logic [WW-1:0] ld_word = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smt_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_smt_store_buffer (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .retire(retire), .flush(flush), .cm_valid(cm_valid), .cm_ready(cm_ready),
        .cm_tid(cm_tid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask),
        .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_word(ld_word), .ld_mask(ld_mask),
        .ld_hit(ld_hit), .ld_blocked(ld_blocked), .ld_data(ld_data));

    // reference model
    ent_t q0[$], q1[$];
    int   r0 = 0, r1 = 0;
    bit   m_last = 1'b1, m_lock = 1'b0, m_sel = 1'b0;

    function automatic int qs(bit t);
        return t ? q1.size() : q0.size();
    endfunction
    function automatic ent_t qe(bit t, int i);
        return t ? q1[i] : q0[i];
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] pick_mask();
        case ($urandom_range(0, 4))
            0: return 8'hff;
            1: return 8'h0f;
            2: return 8'hf0;
            3: return 8'h03;
            default: return 8'($urandom_range(1, 255));
        endcase
    endfunction

    task automatic drive(input int phase);
        for (int t = 0; t < 2; t++) begin
            st_valid[t] = ($urandom_range(0, 99) < ((phase == 0 && t == 0) ? 90 : 45));
            st_addr[t]  = {27'h0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            st_data[t]  = {$urandom(), $urandom()};
            st_mask[t]  = pick_mask();
            retire[t]   = (phase == 0) ? 1'b0 : ($urandom_range(0, 99) < 40);
            flush[t]    = (phase == 0) ? 1'b0 : ($urandom_range(0, 99) < 3);
        end
        cm_ready = (phase == 2) ? ($urandom_range(0, 99) < 25) : ($urandom_range(0, 99) < 70);
        ld_valid = ($urandom_range(0, 99) < 85);
        ld_tid   = 1'($urandom_range(0, 1));
        ld_word  = WW'($urandom_range(0, 3));
        ld_mask  = pick_mask();
    endtask

    bit            p_stall = 1'b0;
    logic [127:0]  p_pay;

    task automatic step();
        bit req0, req1, ev, es, fire, hit, blk, rok, popt;
        bit [1:0] erdy;
        ent_t e, he;
        int   sz;
        logic [DW-1:0] fd;
        // expected outputs
        for (int t = 0; t < 2; t++)
            erdy[t] = (qs(1'(t)) < DEPTH) && !flush[t];
        chk(flush != 0 ? "R3 R9 st_ready" : "R3 st_ready", 128'(st_ready), 128'(erdy));
        req0 = r0 > 0; req1 = r1 > 0;
        if (m_lock) es = m_sel;
        else if (req0 && req1) es = !m_last;
        else es = req1;
        ev = req0 || req1;
        chk("R4 R10 cm_valid", 128'(cm_valid), 128'(ev));
        if (ev) begin
            he = qe(es, 0);
            chk("R5 cm_tid", 128'(cm_tid), 128'(es));
            chk("R4 R11 cm_payload", {cm_addr, cm_mask, cm_data}, {he.a, he.m, he.d});
        end
        if (p_stall)
            chk("R6 held_payload", {cm_valid, cm_tid, cm_addr, cm_mask, cm_data}, p_pay);
        p_stall = ev && !cm_ready;
        p_pay   = {cm_valid, cm_tid, cm_addr, cm_mask, cm_data};
        // probe: only the probing thread's entries
        hit = 1'b0; blk = 1'b0; fd = '0;
        begin
            bit found = 1'b0;
            ent_t s;
            for (int i = 0; i < qs(ld_tid); i++) begin
                e = qe(ld_tid, i);
                if (e.a[AW-1:3] == ld_word && (e.m & ld_mask) != 0) begin
                    found = 1'b1; s = e;
                end
            end
            if (found && ld_valid) begin
                if ((s.m & ld_mask) == ld_mask) begin hit = 1'b1; fd = s.d; end
                else blk = 1'b1;
            end
        end
        chk("R2 R7 R8 R11 ld_flags", {ld_hit, ld_blocked}, {hit, blk});
        if (hit) chk("R2 R7 R8 ld_data", 128'(ld_data), 128'(fd));
        // advance the model by one edge
        fire = ev && cm_ready;
        for (int t = 0; t < 2; t++) begin
            popt = fire && (es == 1'(t));
            sz = qs(1'(t));
            if (flush[t]) begin
                if (t == 0) begin while (q0.size() > r0) void'(q0.pop_back()); end
                else        begin while (q1.size() > r1) void'(q1.pop_back()); end
                if (popt) begin
                    if (t == 0) begin void'(q0.pop_front()); r0--; end
                    else        begin void'(q1.pop_front()); r1--; end
                end
            end else begin
                rok = retire[t] && ((t == 0 ? r0 : r1) < sz);
                if (t == 0) begin
                    if (popt) void'(q0.pop_front());
                    r0 = r0 + int'(rok) - int'(popt);
                    if (st_valid[t] && erdy[t]) q0.push_back('{st_addr[t], st_data[t], st_mask[t]});
                end else begin
                    if (popt) void'(q1.pop_front());
                    r1 = r1 + int'(rok) - int'(popt);
                    if (st_valid[t] && erdy[t]) q1.push_back('{st_addr[t], st_data[t], st_mask[t]});
                end
            end
        end
        if (fire) m_last = es;
        m_lock = ev && !cm_ready;
        m_sel  = es;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ld_valid = 1'b1; ld_mask = 8'hff; ld_word = '0;
        #2;
        // R1 reset state
        chk("R1 st_ready", 128'(st_ready), 128'(2'b11));
        chk("R1 cm_valid", 128'(cm_valid), 128'(0));
        chk("R1 probe", {ld_hit, ld_blocked}, 128'(0));
        for (int c = 0; c < CYCLES; c++) begin
            @(negedge clk);
            drive(c < 300 ? 0 : (c < 4000 ? 1 : 2));
            #2;
            step();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #((CYCLES + 200) * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule